// File: doc/BRIEF.md
# Link Mode Arbiter for a 10/100 Copper PHY

This block decides how a 10/100 twisted-pair port brings its link up. After a restart it sends fast link pulse bursts and listens to the line. A partner that answers with fast link pulse bursts is handled by exchanging abilities and picking the best common mode. A legacy partner that sends only normal link pulses, or only 100 Mb/s idle, is resolved by parallel detection to half duplex at the matching speed. When the negotiation strap is low, all of this is skipped and the speed and duplex come straight from the strap pins.

The inputs are abstract indications from the line receiver, each a one-cycle event or a level. The block does not recognise pulse timing. Its outputs are the resolved speed and duplex, a completion flag, a link-up level, a select that tells the transmitter which kind of signalling to send, and three sticky flags that record which arbitration states were entered. All timers count clock cycles and are set by parameters. A link-down power-saving enable silences every kind of link signalling while the link is absent.

Top module: `linkmode_arbiter`

## Requirements
- R1: After `rst_n` is released with `strap_an_en` high, the block enters the pulse-burst send state within two cycles. In that state `tx_pulse_sel` is 3. The select encoding is 0 = silent, 1 = normal link pulses, 2 = 100 Mb/s idle, 3 = fast link pulse bursts. In that state `speed100`, `full_duplex`, `an_complete` and all three flags are 0.
- R2: A `rx_flp` event in the send state moves the block to ability detection and sets `flag_abd`. After `ABD_BURSTS` further `rx_flp` events, the block resolves, sets `an_complete` and `flag_lsc`, and enters link check.
- R3: Resolution uses `local_ability & partner_ability`, sampled with the last burst. The bit order is bit 3 = 100 full, bit 2 = 100 half, bit 1 = 10 full, bit 0 = 10 half. The highest set bit wins and gives `{speed100, full_duplex}` equal to its index. An empty AND returns the block to the send state without completing.
- R4: An `rx_nlp` event alone in the send state opens a window of `PD_WINDOW` cycles. At the end of the window, if only normal link pulses were seen, the result is 10 Mb/s half duplex: `flag_lsc` is set and `an_complete` stays 0.
- R5: If only `rx_idle100` was seen in the window, the result is 100 Mb/s half duplex.
- R6: If both legacy kinds are seen within one window, the block sets `flag_pdf`, resolves nothing, and returns to the send state.
- R7: With `strap_an_en` low at restart, the block stays in forced mode. In forced mode `speed100` and `full_duplex` follow `strap_speed100` and `strap_full_dup`, the select is 2 for 100 Mb/s and 1 for 10 Mb/s, and no flag is set.
- R8: A `soft_reset` cycle or `rst_n` low clears the flags and the resolution and restarts the arbitration. The negotiation strap is sampled again on each restart.
- R9: In link check or link up, `link_ok` low for `LINK_FAIL` consecutive cycles returns the block to the send state and clears the resolution and `an_complete`. A shorter dropout has no effect.
- R10: While `lpsave_en` is high and `link_ok` is low, `tx_pulse_sel` is 0.
- R11: `link_up` is high in the link-up state, which is reached from link check one cycle after `link_ok` is high. In forced mode `link_up` equals `link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous restart request from the control register |
| strap_an_en | input | 1 | Negotiation enable strap |
| strap_speed100 | input | 1 | Forced speed strap, 1 = 100 Mb/s |
| strap_full_dup | input | 1 | Forced duplex strap, 1 = full |
| lpsave_en | input | 1 | Link-down power-saving enable |
| rx_flp | input | 1 | One-cycle event: fast link pulse burst received |
| rx_nlp | input | 1 | One-cycle event: normal link pulse received |
| rx_idle100 | input | 1 | One-cycle event: 100 Mb/s idle received |
| link_ok | input | 1 | Receiver link status level |
| local_ability | input | 4 | Local abilities, bit order as in R3 |
| partner_ability | input | 4 | Partner abilities from the received bursts |
| speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex |
| an_complete | output | 1 | Negotiation finished with a common mode |
| link_up | output | 1 | Link established |
| tx_pulse_sel | output | 2 | Transmit signalling select, encoding in R1 |
| flag_abd | output | 1 | Sticky: ability-detect state entered |
| flag_pdf | output | 1 | Sticky: parallel-detection fault entered |
| flag_lsc | output | 1 | Sticky: link-status-check state entered |

## Verification
The hardest case to reach from the ports is a detection fault. The stimulus must place both legacy signal kinds inside one window, and the second one must fall late enough that it only joins the first inside the window. The bench sends a normal link pulse, waits several cycles, and then sends an idle event before the window counter expires. A second hard case is a link dropout one cycle shorter than the failure timer, which must leave the resolution alone. The bench drives both this dropout and the full-length one and compares every output against its behavioural model on every cycle.

// File: rtl/linkmode_pkg.sv
package linkmode_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_TX_FLP, ST_ABIL, ST_PD_WIN,
    ST_PD_FAULT, ST_LCHK, ST_LINK_UP, ST_FORCED
  } lm_state_e;

  typedef enum logic [1:0] {
    TXP_OFF  = 2'd0,
    TXP_NLP  = 2'd1,
    TXP_IDLE = 2'd2,
    TXP_FLP  = 2'd3
  } txp_e;

  localparam int MODE_N = 4;
  localparam int MODE_W = $clog2(MODE_N);
endpackage

// File: rtl/lm_span_ctr.sv
module lm_span_ctr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = inc && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lm_mode_pick.sv
module lm_mode_pick
  import linkmode_pkg::*;
(
  input  logic [MODE_N-1:0] local_ab,
  input  logic [MODE_N-1:0] partner_ab,
  output logic              valid,
  output logic              spd,
  output logic              dup
);
  logic [MODE_N-1:0] common;
  logic [MODE_W-1:0] idx;

  assign common = local_ab & partner_ab;

  // higher index overwrites lower: last hit is the highest-priority mode
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < MODE_N; i++) begin
      if (common[i]) begin
        valid = 1'b1;
        idx   = MODE_W'(i);
      end
    end
  end

  assign spd = idx[1];
  assign dup = idx[0];
endmodule

// File: rtl/lm_fsm.sv
module lm_fsm
  import linkmode_pkg::*;
#(
  parameter int PD_WINDOW  = 16,
  parameter int ABD_BURSTS = 3,
  parameter int LINK_FAIL  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_reset,
  input  logic       strap_an_en,
  input  logic       strap_speed100,
  input  logic       strap_full_dup,
  input  logic       lpsave_en,
  input  logic       rx_flp,
  input  logic       rx_nlp,
  input  logic       rx_idle100,
  input  logic       link_ok,
  input  logic       pick_valid,
  input  logic       pick_spd,
  input  logic       pick_dup,
  output logic       speed100,
  output logic       full_duplex,
  output logic       an_complete,
  output logic       link_up,
  output logic [1:0] tx_pulse_sel,
  output logic       flag_abd,
  output logic       flag_pdf,
  output logic       flag_lsc
);
  lm_state_e st;
  logic res_spd, res_dup, an_done;
  logic seen_nlp, seen_idle, seen_nlp_n, seen_idle_n;
  logic win_done, burst_done, fail_done;
  logic in_link, fail_clr;
  txp_e txp;

  assign seen_nlp_n  = seen_nlp  | rx_nlp;
  assign seen_idle_n = seen_idle | rx_idle100;
  assign in_link     = (st == ST_LCHK) || (st == ST_LINK_UP);
  assign fail_clr    = link_ok || !in_link;

  lm_span_ctr #(.LIMIT(PD_WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .clr(st != ST_PD_WIN), .inc(st == ST_PD_WIN),
    .done(win_done)
  );

  lm_span_ctr #(.LIMIT(ABD_BURSTS)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .clr(st != ST_ABIL), .inc((st == ST_ABIL) && rx_flp),
    .done(burst_done)
  );

  lm_span_ctr #(.LIMIT(LINK_FAIL)) u_fail (
    .clk(clk), .rst_n(rst_n),
    .clr(fail_clr), .inc(!fail_clr),
    .done(fail_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      res_spd   <= 1'b0;
      res_dup   <= 1'b0;
      an_done   <= 1'b0;
      seen_nlp  <= 1'b0;
      seen_idle <= 1'b0;
      flag_abd  <= 1'b0;
      flag_pdf  <= 1'b0;
      flag_lsc  <= 1'b0;
    end else if (soft_reset) begin
      st        <= ST_INIT;
      res_spd   <= 1'b0;
      res_dup   <= 1'b0;
      an_done   <= 1'b0;
      seen_nlp  <= 1'b0;
      seen_idle <= 1'b0;
      flag_abd  <= 1'b0;
      flag_pdf  <= 1'b0;
      flag_lsc  <= 1'b0;
    end else begin
      unique case (st)
        ST_INIT: st <= strap_an_en ? ST_TX_FLP : ST_FORCED;
        ST_TX_FLP: begin
          if (rx_flp) begin
            st       <= ST_ABIL;
            flag_abd <= 1'b1;
          end else if (rx_nlp || rx_idle100) begin
            st        <= ST_PD_WIN;
            seen_nlp  <= rx_nlp;
            seen_idle <= rx_idle100;
          end
        end
        ST_ABIL: begin
          if (burst_done) begin
            if (pick_valid) begin
              st       <= ST_LCHK;
              flag_lsc <= 1'b1;
              res_spd  <= pick_spd;
              res_dup  <= pick_dup;
              an_done  <= 1'b1;
            end else begin
              st <= ST_TX_FLP;
            end
          end
        end
        ST_PD_WIN: begin
          seen_nlp  <= seen_nlp_n;
          seen_idle <= seen_idle_n;
          if (win_done) begin
            if (seen_nlp_n && seen_idle_n) begin
              st       <= ST_PD_FAULT;
              flag_pdf <= 1'b1;
            end else begin
              st       <= ST_LCHK;
              flag_lsc <= 1'b1;
              res_spd  <= seen_idle_n;
              res_dup  <= 1'b0;
            end
          end
        end
        ST_PD_FAULT: st <= ST_TX_FLP;
        ST_LCHK, ST_LINK_UP: begin
          if (fail_done) begin
            st      <= ST_TX_FLP;
            res_spd <= 1'b0;
            res_dup <= 1'b0;
            an_done <= 1'b0;
          end else if (st == ST_LCHK && link_ok) begin
            st <= ST_LINK_UP;
          end
        end
        ST_FORCED: st <= ST_FORCED;
        default:   st <= ST_INIT;
      endcase
    end
  end

  assign speed100    = (st == ST_FORCED) ? strap_speed100 : res_spd;
  assign full_duplex = (st == ST_FORCED) ? strap_full_dup : res_dup;
  assign an_complete = an_done;
  assign link_up     = (st == ST_LINK_UP) || ((st == ST_FORCED) && link_ok);

  always_comb begin
    if (lpsave_en && !link_ok) begin
      txp = TXP_OFF;
    end else begin
      unique case (st)
        ST_INIT:                                     txp = TXP_OFF;
        ST_TX_FLP, ST_ABIL, ST_PD_WIN, ST_PD_FAULT:  txp = TXP_FLP;
        default:                                     txp = speed100 ? TXP_IDLE : TXP_NLP;
      endcase
    end
  end

  assign tx_pulse_sel = txp;
endmodule

// File: rtl/linkmode_arbiter.sv
module linkmode_arbiter
  import linkmode_pkg::*;
#(
  parameter int PD_WINDOW  = 16,
  parameter int ABD_BURSTS = 3,
  parameter int LINK_FAIL  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              strap_an_en,
  input  logic              strap_speed100,
  input  logic              strap_full_dup,
  input  logic              lpsave_en,
  input  logic              rx_flp,
  input  logic              rx_nlp,
  input  logic              rx_idle100,
  input  logic              link_ok,
  input  logic [MODE_N-1:0] local_ability,
  input  logic [MODE_N-1:0] partner_ability,
  output logic              speed100,
  output logic              full_duplex,
  output logic              an_complete,
  output logic              link_up,
  output logic [1:0]        tx_pulse_sel,
  output logic              flag_abd,
  output logic              flag_pdf,
  output logic              flag_lsc
);
  logic pick_valid, pick_spd, pick_dup;

  lm_mode_pick u_pick (
    .local_ab(local_ability), .partner_ab(partner_ability),
    .valid(pick_valid), .spd(pick_spd), .dup(pick_dup)
  );

  lm_fsm #(
    .PD_WINDOW(PD_WINDOW), .ABD_BURSTS(ABD_BURSTS), .LINK_FAIL(LINK_FAIL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
    .strap_an_en(strap_an_en), .strap_speed100(strap_speed100),
    .strap_full_dup(strap_full_dup), .lpsave_en(lpsave_en),
    .rx_flp(rx_flp), .rx_nlp(rx_nlp), .rx_idle100(rx_idle100),
    .link_ok(link_ok),
    .pick_valid(pick_valid), .pick_spd(pick_spd), .pick_dup(pick_dup),
    .speed100(speed100), .full_duplex(full_duplex),
    .an_complete(an_complete), .link_up(link_up),
    .tx_pulse_sel(tx_pulse_sel),
    .flag_abd(flag_abd), .flag_pdf(flag_pdf), .flag_lsc(flag_lsc)
  );
endmodule

// File: rtl/linkmode_checker.sv
module linkmode_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_reset,
  input logic       lpsave_en,
  input logic       link_ok,
  input logic [3:0] local_ability,
  input logic [3:0] partner_ability,
  input logic       speed100,
  input logic       full_duplex,
  input logic       an_complete,
  input logic       link_up,
  input logic [1:0] tx_pulse_sel,
  input logic       flag_abd,
  input logic       flag_pdf,
  input logic       flag_lsc
);
  logic [3:0] q_common;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_common <= '0;
    else        q_common <= local_ability & partner_ability;
  end

  AST_ABD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_abd) |-> $past(soft_reset)); // R8

  AST_PDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_pdf) |-> $past(soft_reset)); // R6

  AST_PICK_IN_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(an_complete) |-> q_common[{speed100, full_duplex}]); // R3

  AST_PD_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_lsc) && !an_complete) |-> !full_duplex); // R4

  AST_LPS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lpsave_en && !link_ok) |-> (tx_pulse_sel == 2'd0)); // R10

  AST_LINKUP_HAS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> ($past(link_ok) || link_ok)); // R11
endmodule

bind linkmode_arbiter linkmode_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
  .lpsave_en(lpsave_en), .link_ok(link_ok),
  .local_ability(local_ability), .partner_ability(partner_ability),
  .speed100(speed100), .full_duplex(full_duplex),
  .an_complete(an_complete), .link_up(link_up),
  .tx_pulse_sel(tx_pulse_sel),
  .flag_abd(flag_abd), .flag_pdf(flag_pdf), .flag_lsc(flag_lsc)
);

// File: tb/linkmode_arbiter_tb.sv
module linkmode_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int B = 3;
  localparam int F = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_reset = 1'b0;
  logic strap_an_en = 1'b1, strap_speed100 = 1'b0, strap_full_dup = 1'b0;
  logic lpsave_en = 1'b0;
  logic rx_flp = 1'b0, rx_nlp = 1'b0, rx_idle100 = 1'b0, link_ok = 1'b0;
  logic [3:0] local_ability = 4'hF, partner_ability = 4'h0;
  logic speed100, full_duplex, an_complete, link_up;
  logic [1:0] tx_pulse_sel;
  logic flag_abd, flag_pdf, flag_lsc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linkmode_arbiter #(.PD_WINDOW(W), .ABD_BURSTS(B), .LINK_FAIL(F)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
    .strap_an_en(strap_an_en), .strap_speed100(strap_speed100),
    .strap_full_dup(strap_full_dup), .lpsave_en(lpsave_en),
    .rx_flp(rx_flp), .rx_nlp(rx_nlp), .rx_idle100(rx_idle100),
    .link_ok(link_ok), .local_ability(local_ability),
    .partner_ability(partner_ability),
    .speed100(speed100), .full_duplex(full_duplex),
    .an_complete(an_complete), .link_up(link_up),
    .tx_pulse_sel(tx_pulse_sel),
    .flag_abd(flag_abd), .flag_pdf(flag_pdf), .flag_lsc(flag_lsc)
  );

  // behavioural reference model
  localparam int M_RESTART = 0, M_SEND = 1, M_ABIL = 2, M_WIN = 3,
                 M_FAULT = 4, M_CHECK = 5, M_UP = 6, M_FORCE = 7;
  int m_phase = M_RESTART;
  int m_win = 0, m_bursts = 0, m_fail = 0;
  bit m_nlp = 0, m_idle = 0;
  bit m_spd = 0, m_dup = 0, m_done = 0;
  bit m_abd = 0, m_pdf = 0, m_lsc = 0;

  task automatic model_clear();
    m_phase = M_RESTART; m_win = 0; m_bursts = 0; m_fail = 0;
    m_nlp = 0; m_idle = 0; m_spd = 0; m_dup = 0; m_done = 0;
    m_abd = 0; m_pdf = 0; m_lsc = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_reset) begin
      model_clear();
    end else begin
      bit linked;
      linked = (m_phase == M_CHECK) || (m_phase == M_UP);
      if (!linked || link_ok) m_fail = 0;
      case (m_phase)
        M_RESTART: m_phase = strap_an_en ? M_SEND : M_FORCE;
        M_SEND: begin
          if (rx_flp) begin
            m_phase = M_ABIL; m_abd = 1; m_bursts = 0;
          end else if (rx_nlp || rx_idle100) begin
            m_phase = M_WIN; m_win = 0; m_nlp = rx_nlp; m_idle = rx_idle100;
          end
        end
        M_ABIL: if (rx_flp) begin
          if (m_bursts == B - 1) begin
            bit found;
            found = 0;
            for (int k = 3; k >= 0; k--) begin
              if (!found && local_ability[k] && partner_ability[k]) begin
                found = 1; m_spd = (k >= 2); m_dup = (k % 2 == 1);
              end
            end
            if (found) begin m_phase = M_CHECK; m_lsc = 1; m_done = 1; end
            else m_phase = M_SEND;
          end else m_bursts++;
        end
        M_WIN: begin
          m_nlp = m_nlp | rx_nlp; m_idle = m_idle | rx_idle100;
          if (m_win == W - 1) begin
            if (m_nlp && m_idle) begin m_phase = M_FAULT; m_pdf = 1; end
            else begin m_phase = M_CHECK; m_lsc = 1; m_spd = m_idle; m_dup = 0; end
          end else m_win++;
        end
        M_FAULT: m_phase = M_SEND;
        M_CHECK, M_UP: begin
          if (!link_ok && m_fail == F - 1) begin
            m_phase = M_SEND; m_spd = 0; m_dup = 0; m_done = 0; m_fail = 0;
          end else begin
            if (!link_ok) m_fail++;
            if (m_phase == M_CHECK && link_ok) m_phase = M_UP;
          end
        end
        default: ;
      endcase
    end
  end

  function automatic int exp_speed();
    return (m_phase == M_FORCE) ? int'(strap_speed100) : int'(m_spd);
  endfunction
  function automatic int exp_dup();
    return (m_phase == M_FORCE) ? int'(strap_full_dup) : int'(m_dup);
  endfunction
  function automatic int exp_tx();
    if (lpsave_en && !link_ok) return 0;
    if (m_phase == M_RESTART) return 0;
    if (m_phase >= M_SEND && m_phase <= M_FAULT) return 3;
    return exp_speed() ? 2 : 1;
  endfunction
  function automatic int exp_up();
    return ((m_phase == M_UP) || (m_phase == M_FORCE && link_ok)) ? 1 : 0;
  endfunction

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R3",  "model speed100",    int'(speed100),     exp_speed());
      check_val("R3",  "model full_duplex", int'(full_duplex),  exp_dup());
      check_val("R2",  "model an_complete", int'(an_complete),  int'(m_done));
      check_val("R10", "model tx_pulse_sel", int'(tx_pulse_sel), exp_tx());
      check_val("R11", "model link_up",     int'(link_up),      exp_up());
      check_val("R2",  "model flag_abd",    int'(flag_abd),     int'(m_abd));
      check_val("R6",  "model flag_pdf",    int'(flag_pdf),     int'(m_pdf));
      check_val("R4",  "model flag_lsc",    int'(flag_lsc),     int'(m_lsc));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic pulse_flp();
    rx_flp = 1; step(1); rx_flp = 0; step(1);
  endtask
  task automatic restart();
    soft_reset = 1; step(1); soft_reset = 0; step(2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; step(2);
    // R1: reset state
    check_val("R1", "tx after reset", tx_pulse_sel, 3);
    check_val("R1", "speed after reset", speed100, 0);
    check_val("R1", "flags after reset", {flag_abd, flag_pdf, flag_lsc}, 0);

    // R2 / R3: negotiation, common 0110 -> 100 half
    local_ability = 4'b1111; partner_ability = 4'b0110;
    pulse_flp();
    check_val("R2", "flag_abd", flag_abd, 1);
    for (int i = 0; i < B; i++) pulse_flp();
    check_val("R2", "an_complete", an_complete, 1);
    check_val("R3", "speed/dup 100H", {speed100, full_duplex}, 2);
    check_val("R2", "flag_lsc", flag_lsc, 1);
    link_ok = 1; step(2);
    check_val("R11", "link_up", link_up, 1);
    // R9: short dropout
    link_ok = 0; step(F - 1); link_ok = 1; step(1);
    check_val("R9", "short dropout keeps", an_complete, 1);
    link_ok = 0; step(F + 2);
    check_val("R9", "long dropout restarts", tx_pulse_sel, 3);
    check_val("R9", "resolution cleared", {speed100, an_complete}, 0);

    // R3: empty intersection
    local_ability = 4'b0111; partner_ability = 4'b1000;
    for (int i = 0; i < B + 1; i++) pulse_flp();
    check_val("R3", "empty common", an_complete, 0);
    check_val("R3", "empty common tx", tx_pulse_sel, 3);
    local_ability = 4'b1111; partner_ability = 4'b0011;
    for (int i = 0; i < B + 1; i++) pulse_flp();
    check_val("R3", "10 full chosen", {speed100, full_duplex}, 1);
    step(F + 2);

    // R8: soft reset clears flags
    restart();
    check_val("R8", "flags cleared", {flag_abd, flag_lsc}, 0);

    // R4: NLP only
    rx_nlp = 1; step(1); rx_nlp = 0; step(W + 1);
    check_val("R4", "10 half", {speed100, full_duplex, flag_lsc, an_complete}, 4'b0010);
    restart();
    // R5: idle only
    rx_idle100 = 1; step(1); rx_idle100 = 0; step(W + 1);
    check_val("R5", "100 half", {speed100, full_duplex, flag_lsc}, 3'b101);
    restart();
    // R6: both in one window, idle arrives late
    rx_nlp = 1; step(1); rx_nlp = 0; step(W - 3);
    rx_idle100 = 1; step(1); rx_idle100 = 0; step(4);
    check_val("R6", "fault flag", flag_pdf, 1);
    check_val("R6", "no resolution", {speed100, flag_lsc}, 0);
    check_val("R6", "back to send", tx_pulse_sel, 3);

    // R10: power save
    restart();
    lpsave_en = 1; link_ok = 0; step(2);
    check_val("R10", "silent", tx_pulse_sel, 0);
    link_ok = 1; step(1);
    check_val("R10", "link present", tx_pulse_sel, 3);
    lpsave_en = 0; link_ok = 0;

    // R7: forced mode
    strap_an_en = 0; strap_speed100 = 1; strap_full_dup = 1; link_ok = 1;
    restart();
    check_val("R7", "forced 100F", {speed100, full_duplex}, 3);
    check_val("R7", "forced idle tx", tx_pulse_sel, 2);
    check_val("R11", "forced link_up", link_up, 1);
    rx_flp = 1; step(1); rx_flp = 0; step(1);
    check_val("R7", "no flags forced", {flag_abd, flag_pdf, flag_lsc}, 0);
    strap_speed100 = 0; strap_full_dup = 0; step(1);
    check_val("R7", "forced 10H nlp", {speed100, full_duplex, tx_pulse_sel}, 4'b0001);

    // R8: pin reset restarts negotiation
    strap_an_en = 1; link_ok = 0;
    rst_n = 0; step(2); rst_n = 1; step(2);
    check_val("R8", "pin reset to send", tx_pulse_sel, 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule